// File: doc/BRIEF.md
# Scanline and Frame Event Sequencer

This block turns the system clock into video line timing. A clock divider marks the end of each scanline period. A line counter advances once per period and wraps at the frame total. A second counter, driven by the same line tick, keeps an audio service cadence. All outputs are single-cycle strobes that a chip can use as clock enables or as interrupt sources. The current line number is also an output.

Two video standards are supported: a 60 Hz standard with 263 lines and a 50 Hz standard with 313 lines. Each standard has its own line period, its own vertical-blank line and its own audio cadence. A select input chooses the standard. The block reads that input only at a frame boundary, so a frame never mixes the two timings. The end-of-frame strobe doubles as the vertical interrupt request.

Top module: `scanline_seq`

## Requirements
- R1: While reset is held, all strobes are low and the line number is 0. The standard applied to the first frame is the select value present during reset.
- R2: `hsync_o` is high for exactly one cycle at the end of every line period. The line period in clocks is floor(CLK_HZ / (rate × lines)). For the 60 Hz standard (select 0) this is rate 60 and 263 lines. For the 50 Hz standard (select 1) it is rate 50 and 313 lines. The first tick comes one full period after reset is released.
- R3: `line_o` changes only in a cycle where `hsync_o` is high. Unless the frame wraps, it is then one more than its previous value.
- R4: When the line count would reach the frame total (263 or 313), `line_o` becomes 0 instead. In that same cycle `frame_o` pulses together with `hsync_o`. `frame_o` is the vertical interrupt request.
- R5: `vblank_o` pulses together with `hsync_o` exactly when `line_o` becomes the blank-start line: 240 at 60 Hz and 256 at 50 Hz. It never pulses at any other time.
- R6: `audio_o` pulses together with `hsync_o` on every 23rd line tick at 60 Hz and every 22nd at 50 Hz. Its counter then restarts at zero. A frame wrap does not reset it. If a change of standard leaves the count at or above the new cadence, the next tick pulses and restarts it.
- R7: `std_sel_i` is sampled only in the cycle in which `frame_o` is high. Changes at any other time, including changes that are reverted within a frame, have no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| std_sel_i | input | 1 | Standard select: 0 = 60 Hz timing, 1 = 50 Hz timing |
| hsync_o | output | 1 | One-cycle end-of-line tick |
| vblank_o | output | 1 | One-cycle vertical-blank-start strobe |
| frame_o | output | 1 | One-cycle end-of-frame strobe and vertical interrupt request |
| audio_o | output | 1 | One-cycle audio-update strobe |
| line_o | output | LINE_W | Current line number within the frame |

## Verification
The bench switches the standard across several frames, flips the select mid-frame and then reverts it, and restarts from reset with each select value. A design that samples the select continuously would shift the line period in the middle of a frame. A design that latched it late would keep the old frame length for one more frame. The bench also lets the audio cadence run across frame wraps. A design that cleared the audio counter at the frame boundary would move every later audio strobe. A design with an off-by-one in the wrap or blank compare would put `frame_o` or `vblank_o` one line away from the expected one.

// File: rtl/sls_pkg.sv
package sls_pkg;

   typedef enum logic {
      STD_60 = 1'b0,
      STD_50 = 1'b1
   } vstd_e;

   // clocks per scanline for a given system clock, frame rate and line total
   function automatic int unsigned line_clks(input longint unsigned hz,
                                             input int unsigned rate,
                                             input int unsigned lines);
      longint unsigned den;
      den = 64'(rate) * 64'(lines);
      return 32'(hz / den);
   endfunction

   // bits needed to hold values 0..v
   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sls_line_div.sv
module sls_line_div #(
   parameter int unsigned W = 12
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] period_i,
   output logic         tick_o
);

   logic [W-1:0] cnt_q;

   // tick in the last clock of the period; ">=" tolerates a shorter period
   // selected while the count is already past it
   assign tick_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period_i};

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sls_wrap_cnt.sv
module sls_wrap_cnt #(
   parameter int unsigned W = 9
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         step_i,
   input  logic [W-1:0] limit_i,
   input  logic [W-1:0] mark_i,
   output logic [W-1:0] count_o,
   output logic         wrap_o,
   output logic         mark_o
);

   logic [W:0] nxt;

   assign nxt = {1'b0, count_o} + 1'b1;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         count_o <= '0;
         wrap_o  <= 1'b0;
         mark_o  <= 1'b0;
      end else begin
         wrap_o <= 1'b0;
         mark_o <= 1'b0;
         if (step_i) begin
            if (nxt >= {1'b0, limit_i}) begin
               count_o <= '0;
               wrap_o  <= 1'b1;
            end else begin
               count_o <= nxt[W-1:0];
               mark_o  <= (nxt[W-1:0] == mark_i);
            end
         end
      end
   end

endmodule

// File: rtl/scanline_seq.sv
module scanline_seq
   import sls_pkg::*;
#(
   parameter longint unsigned CLK_HZ  = 64'd33868800,
   parameter int unsigned     RATE_A  = 60,
   parameter int unsigned     LINES_A = 263,
   parameter int unsigned     VBL_A   = 240,
   parameter int unsigned     AUD_A   = 23,
   parameter int unsigned     RATE_B  = 50,
   parameter int unsigned     LINES_B = 313,
   parameter int unsigned     VBL_B   = 256,
   parameter int unsigned     AUD_B   = 22,
   parameter int unsigned     LINE_W  = bits_for(max2(LINES_A, LINES_B))
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              std_sel_i,
   output logic              hsync_o,
   output logic              vblank_o,
   output logic              frame_o,
   output logic              audio_o,
   output logic [LINE_W-1:0] line_o
);

   localparam int unsigned PER_A = line_clks(CLK_HZ, RATE_A, LINES_A);
   localparam int unsigned PER_B = line_clks(CLK_HZ, RATE_B, LINES_B);
   localparam int unsigned DIV_W = bits_for(max2(PER_A, PER_B));
   localparam int unsigned AUD_W = bits_for(max2(AUD_A, AUD_B));

   localparam logic [DIV_W-1:0]  PER_A_V = DIV_W'(PER_A);
   localparam logic [DIV_W-1:0]  PER_B_V = DIV_W'(PER_B);
   localparam logic [LINE_W-1:0] TOT_A_V = LINE_W'(LINES_A);
   localparam logic [LINE_W-1:0] TOT_B_V = LINE_W'(LINES_B);
   localparam logic [LINE_W-1:0] VBL_A_V = LINE_W'(VBL_A);
   localparam logic [LINE_W-1:0] VBL_B_V = LINE_W'(VBL_B);
   localparam logic [AUD_W-1:0]  AUD_A_V = AUD_W'(AUD_A);
   localparam logic [AUD_W-1:0]  AUD_B_V = AUD_W'(AUD_B);

   // elaboration-time parameter checks
   generate
      if (PER_A < 2 || PER_B < 2) begin : g_bad_period
         $error("scanline_seq: line period must be at least two clocks");
      end
      if (VBL_A == 0 || VBL_A >= LINES_A || VBL_B == 0 || VBL_B >= LINES_B) begin : g_bad_vbl
         $error("scanline_seq: blank-start line must lie inside the frame");
      end
      if (AUD_A < 1 || AUD_B < 1) begin : g_bad_aud
         $error("scanline_seq: audio cadence must be at least one line");
      end
      if (LINE_W < bits_for(max2(LINES_A, LINES_B))) begin : g_bad_width
         $error("scanline_seq: LINE_W too narrow for the frame total");
      end
   endgenerate

   vstd_e             std_q;
   logic              tick;
   logic [DIV_W-1:0]  per_sel;
   logic [LINE_W-1:0] tot_sel;
   logic [LINE_W-1:0] vbl_sel;
   logic [AUD_W-1:0]  aud_sel;
   logic [AUD_W-1:0]  unused_aud_cnt;
   logic              unused_aud_mark;

   // active standard: loaded during reset, then only at frame wrap
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         std_q <= vstd_e'(std_sel_i);
      end else if (frame_o) begin
         std_q <= vstd_e'(std_sel_i);
      end
   end

   always_comb begin
      if (std_q == STD_50) begin
         per_sel = PER_B_V;
         tot_sel = TOT_B_V;
         vbl_sel = VBL_B_V;
         aud_sel = AUD_B_V;
      end else begin
         per_sel = PER_A_V;
         tot_sel = TOT_A_V;
         vbl_sel = VBL_A_V;
         aud_sel = AUD_A_V;
      end
   end

   sls_line_div #(.W(DIV_W)) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .period_i (per_sel),
      .tick_o   (tick)
   );

   sls_wrap_cnt #(.W(LINE_W)) u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (tick),
      .limit_i (tot_sel),
      .mark_i  (vbl_sel),
      .count_o (line_o),
      .wrap_o  (frame_o),
      .mark_o  (vblank_o)
   );

   // audio cadence: wraps at its own limit, never cleared by the frame wrap
   sls_wrap_cnt #(.W(AUD_W)) u_aud (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (tick),
      .limit_i (aud_sel),
      .mark_i  (aud_sel),
      .count_o (unused_aud_cnt),
      .wrap_o  (audio_o),
      .mark_o  (unused_aud_mark)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hsync_o <= 1'b0;
      end else begin
         hsync_o <= tick;
      end
   end

endmodule

// File: rtl/sls_checker.sv
module sls_checker
   import sls_pkg::*;
#(
   parameter longint unsigned CLK_HZ  = 64'd33868800,
   parameter int unsigned     RATE_A  = 60,
   parameter int unsigned     LINES_A = 263,
   parameter int unsigned     VBL_A   = 240,
   parameter int unsigned     RATE_B  = 50,
   parameter int unsigned     LINES_B = 313,
   parameter int unsigned     VBL_B   = 256,
   parameter int unsigned     LINE_W  = 9
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              hsync_o,
   input logic              vblank_o,
   input logic              frame_o,
   input logic              audio_o,
   input logic [LINE_W-1:0] line_o,
   input logic              std_q
);

   localparam int unsigned PER_A = line_clks(CLK_HZ, RATE_A, LINES_A);
   localparam int unsigned PER_B = line_clks(CLK_HZ, RATE_B, LINES_B);

   int unsigned gap_q;
   int unsigned exp_per;
   int unsigned exp_vbl;
   int unsigned exp_tot;

   assign exp_per = std_q ? PER_B : PER_A;
   assign exp_vbl = std_q ? VBL_B : VBL_A;
   assign exp_tot = std_q ? LINES_B : LINES_A;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         gap_q <= 0;
      end else if (hsync_o) begin
         gap_q <= 1;
      end else begin
         gap_q <= gap_q + 1;
      end
   end

   p_hsync_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hsync_o |-> gap_q == exp_per);

   p_hsync_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hsync_o |=> !hsync_o);

   p_line_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hsync_o && !frame_o) |-> line_o == $past(line_o) + 1'b1);

   p_line_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hsync_o |-> $stable(line_o));

   p_frame_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_o |-> (hsync_o && line_o == '0));

   p_line_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      32'(line_o) < exp_tot);

   p_vblank_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vblank_o |-> (hsync_o && 32'(line_o) == exp_vbl));

   p_audio_hsync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      audio_o |-> hsync_o);

   p_std_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_o |=> $stable(std_q));

endmodule

bind scanline_seq sls_checker #(
   .CLK_HZ  (CLK_HZ),
   .RATE_A  (RATE_A),
   .LINES_A (LINES_A),
   .VBL_A   (VBL_A),
   .RATE_B  (RATE_B),
   .LINES_B (LINES_B),
   .VBL_B   (VBL_B),
   .LINE_W  (LINE_W)
) u_sls_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .hsync_o  (hsync_o),
   .vblank_o (vblank_o),
   .frame_o  (frame_o),
   .audio_o  (audio_o),
   .line_o   (line_o),
   .std_q    (std_q)
);

// File: tb/test_scanline_seq.sv
module test_scanline_seq;

   localparam longint unsigned TB_HZ = 64'd94000;   // 5 clocks/line at 60 Hz, 6 at 50 Hz
   localparam int LW = 9;

   typedef struct {
      longint cyc;
      bit     fr;
      bit     vb;
      bit     au;
      int     line;
   } ev_t;

   typedef struct {
      longint cyc;
      bit     val;
   } chg_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          std_sel = 1'b0;
   logic          hsync, vblank, frame, audio;
   logic [LW-1:0] line;

   longint cyc = 0;
   int     nchk = 0;
   int     nfail = 0;
   int     wd = 0;
   bit     hung = 1'b0;
   ev_t    exp_q[$];
   chg_t   chg_q[$];

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   scanline_seq #(.CLK_HZ(TB_HZ)) i_scanline_seq (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .std_sel_i (std_sel),
      .hsync_o   (hsync),
      .vblank_o  (vblank),
      .frame_o   (frame),
      .audio_o   (audio),
      .line_o    (line)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // mid-frame select values: A at line 100, B at line 200 (B is what the wrap sees)
   function automatic bit sel_a(input int pat, input int f);
      bit [4:0] a0 = 5'b11001;
      return (pat == 0) ? a0[f] : 1'b0;
   endfunction

   function automatic bit sel_b(input int pat, input int f);
      bit [4:0] b0 = 5'b10011;
      return (pat == 0) ? b0[f] : 1'b1;
   endfunction

   // driver: expected event stream derived from the requirements
   task automatic plan_run(input bit std0, input int nfr, input int pat, output longint last);
      longint t = 0;
      int     ln = 0;
      int     aud = 0;
      bit     cur = std0;
      for (int f = 0; f < nfr; f++) begin
         int tot  = cur ? 313 : 263;
         int vbl  = cur ? 256 : 240;
         int audp = cur ? 22 : 23;
         int per  = cur ? int'(TB_HZ / (50 * 313)) : int'(TB_HZ / (60 * 263));
         for (int k = 0; k < tot; k++) begin
            ev_t e;
            t  += per;
            ln++;
            e.fr = 1'b0;
            e.vb = 1'b0;
            e.au = 1'b0;
            if (ln >= tot) begin
               ln   = 0;
               e.fr = 1'b1;
            end else if (ln == vbl) begin
               e.vb = 1'b1;
            end
            aud++;
            if (aud >= audp) begin
               aud  = 0;
               e.au = 1'b1;
            end
            e.cyc  = t;
            e.line = ln;
            exp_q.push_back(e);
            if (ln == 100) chg_q.push_back('{t + 3, sel_a(pat, f)});
            if (ln == 200) chg_q.push_back('{t + 3, sel_b(pat, f)});
         end
         cur = sel_b(pat, f);
      end
      last = t;
   endtask

   // monitor: applies scheduled select changes, pops and compares events
   task automatic monitor(input longint last);
      bit first = 1'b1;
      while (cyc < last + 4 && !hung) begin
         @(negedge clk);
         wd++;
         if (wd > 100000) begin
            hung = 1'b1;
            chk(1'b0, "R2 watchdog expired", wd, 100000);
         end
         if (chg_q.size() != 0 && chg_q[0].cyc == cyc) begin
            std_sel = chg_q[0].val;
            void'(chg_q.pop_front());
         end
         if (hsync || vblank || frame || audio) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected strobe", cyc, -1);
            end else begin
               ev_t e = exp_q.pop_front();
               chk(cyc == e.cyc, first ? "R1 R2 first tick cycle" : "R2 R7 tick cycle", cyc, e.cyc);
               chk(hsync == 1'b1, "R2 hsync with event", hsync, 1);
               chk(int'(line) == e.line, "R3 line number", line, e.line);
               chk(frame == e.fr, "R4 frame strobe", frame, e.fr);
               chk(vblank == e.vb, "R5 vblank strobe", vblank, e.vb);
               chk(audio == e.au, "R6 audio strobe", audio, e.au);
               first = 1'b0;
            end
         end
      end
      chk(exp_q.size() == 0, "R2 missing ticks", exp_q.size(), 0);
      exp_q.delete();
      chg_q.delete();
   endtask

   task automatic reset_check();
      repeat (4) @(negedge clk);
      chk(!hsync && !vblank && !frame && !audio, "R1 strobes low in reset",
          {hsync, vblank, frame, audio}, 0);
      chk(line == '0, "R1 line zero in reset", line, 0);
   endtask

   initial begin
      longint last;
      // run 1: start at 60 Hz, switch standards across five frames with glitches
      std_sel = 1'b0;
      rst_n   = 1'b0;
      reset_check();
      plan_run(1'b0, 5, 0, last);
      rst_n = 1'b1;
      monitor(last);

      // run 2: reset with 50 Hz selected, revert a mid-frame flip each frame
      if (!hung) begin
         @(negedge clk);
         rst_n   = 1'b0;
         std_sel = 1'b1;
         reset_check();
         plan_run(1'b1, 2, 1, last);
         rst_n = 1'b1;
         monitor(last);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule